// File: doc/BRIEF.md
# Indirect Glyph Store with Auto-Advancing Pointer

This block holds the user-definable glyphs of a dot-matrix character display: 24 glyphs of 5 columns each, one 7-bit word per column, 120 words in all. Software reaches the whole store through one 8-bit register. A byte with bit 7 set moves an internal cursor. A byte with bit 7 clear stores its low seven bits at the cursor. A read request returns the word under the cursor. After every data access the cursor steps forward by one, so a full glyph set can be loaded or dumped as one long byte stream once the cursor is placed.

The cursor is visible on the register as values 0x80 to 0xF7: location k is cursor value 0x80 + k, and glyph g column c sits at location 5g + c. Writing a cursor value of 0xF8 to 0xFF places the cursor at 0x80 instead. After the last location has been accessed, the cursor parks beyond the end. Further data accesses then neither store nor move it until a new cursor value is written.

Writes and read requests arrive on valid/ready streams, and read data leaves on a third valid/ready stream. The write stream is never back-pressured. A read request is held off while a write is offered in the same cycle, or while an earlier response is still waiting for its consumer. An offered request or response must stay asserted with unchanged content until it is accepted. A separate combinational port lets the display scan logic fetch any glyph column by glyph number and column number without touching the cursor.

Top module: `glyph_store`

## Requirements
- R1: After reset the cursor selects location 0 (cursor value 0x80), every location reads as zero and no response is pending.
- R2: An accepted write byte with bit 7 = 0 stores bits 6..0 at the cursor location, then advances the cursor by one.
- R3: An accepted write byte with bit 7 = 1 and value 0x80 to 0xF7 moves the cursor to location (value - 0x80) and stores nothing.
- R4: An accepted write byte from 0xF8 to 0xFF moves the cursor to location 0.
- R5: An accepted read request yields, on the next cycle, a response byte whose bit 7 is 0 and whose bits 6..0 are the word at the cursor, then advances the cursor by one.
- R6: Once location 119 (0xF7) has been written or read, further data writes change no location and further reads return 0x00. The cursor stays parked until the next cursor byte.
- R7: The fetch port returns the word at location 5 x glyph + column, combinationally, for glyph 0..23 and column 0..4. It returns 0 for any glyph or column beyond these ranges, and it never moves the cursor.
- R8: While a response is valid and not accepted, its byte stays unchanged and no new read request is accepted.
- R9: The write stream is always ready. A read request offered in the same cycle as a write is not accepted in that cycle, so the write takes effect first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A register write byte is offered |
| wr_ready | output | 1 | Write byte accepted (always high) |
| wr_byte | input | 8 | Write byte: bit 7 = 1 cursor move, bit 7 = 0 data |
| rd_valid | input | 1 | A read request is offered |
| rd_ready | output | 1 | Read request accepted this cycle |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Consumer takes the response byte |
| rsp_byte | output | 8 | Response byte, bit 7 always 0 |
| glyph_sel | input | 5 | Fetch port glyph number |
| col_sel | input | 3 | Fetch port column number |
| col_bits | output | 7 | Fetch port column word |

## Verification
A reference array and cursor in the bench replay every write and read request, and a scoreboard compares each response byte in order. Streams that place the cursor once and then run straight through a glyph show whether stepping happens exactly once per data access. Cursor bytes just inside and beyond 0xF7 show where clamping and parking begin, and whether parking after a read differs from parking after a write. A write offered together with a read, and a consumer that stalls the response, show the ordering between the two streams and whether a held response is preserved. Fetch port lookups placed between stream accesses show whether locations are addressed correctly and whether the cursor is ever disturbed.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  // Register byte: bit 7 selects a cursor move over a data transfer.
  localparam int unsigned CMD_BIT = 7;
  localparam logic [7:0] CURSOR_BASE = 8'h80;

  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_DATA_WR = 2'd1,
    ACC_CUR_WR  = 2'd2,
    ACC_DATA_RD = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/glyph_cursor.sv
module glyph_cursor
  import glyph_pkg::*;
#(
  parameter int unsigned DEPTH = 120,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_kind_e        acc,
  input  logic [6:0]       cur_off,
  output logic [IDX_W-1:0] idx,
  output logic             parked
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  assign parked = (idx_q == IDX_W'(DEPTH));
  assign idx    = idx_q;

  always_comb begin
    idx_d = idx_q;
    unique case (acc)
      ACC_CUR_WR: begin
        // Offsets past the last location fall back to the first one.
        if (int'(cur_off) >= int'(DEPTH)) idx_d = '0;
        else                              idx_d = IDX_W'(cur_off);
      end
      ACC_DATA_WR, ACC_DATA_RD: begin
        if (!parked) idx_d = idx_q + IDX_W'(1);
      end
      default: idx_d = idx_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/glyph_cells.sv
module glyph_cells #(
  parameter int unsigned NUM_GLYPHS = 24,
  parameter int unsigned GLYPH_COLS = 5,
  parameter int unsigned WORD_W     = 7,
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned GSEL_W     = 5,
  parameter int unsigned CSEL_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic [GSEL_W-1:0] glyph_sel,
  input  logic [CSEL_W-1:0] col_sel,
  output logic [WORD_W-1:0] col_word
);
  localparam int unsigned DEPTH = NUM_GLYPHS * GLYPH_COLS;

  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cells[i] <= '0;
      else if (we && (wr_idx == IDX_W'(i)))   cells[i] <= wr_word;
    end
  end

  // Cursor-side read: a parked cursor matches no location and yields zero.
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (rd_idx == IDX_W'(i)) rd_word = cells[i];
    end
  end

  // Scan-side read by glyph and column.
  logic              sel_ok;
  int unsigned       flat;

  assign sel_ok = (int'(glyph_sel) < int'(NUM_GLYPHS)) &&
                  (int'(col_sel) < int'(GLYPH_COLS));
  assign flat   = int'(glyph_sel) * GLYPH_COLS + int'(col_sel);

  always_comb begin
    col_word = '0;
    if (sel_ok) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        if (flat == i) col_word = cells[i];
      end
    end
  end
endmodule

// File: rtl/glyph_resp.sv
module glyph_resp #(
  parameter int unsigned WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              free,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_byte
);
  logic       valid_q;
  logic [7:0] byte_q;

  assign free      = !valid_q || rsp_ready;
  assign rsp_valid = valid_q;
  assign rsp_byte  = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      byte_q  <= 8'(word);
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/glyph_store.sv
module glyph_store
  import glyph_pkg::*;
#(
  parameter int unsigned NUM_GLYPHS = 24,
  parameter int unsigned GLYPH_COLS = 5,
  parameter int unsigned WORD_W     = 7,
  parameter int unsigned GSEL_W     = 5,
  parameter int unsigned CSEL_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_byte,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_byte,
  input  logic [GSEL_W-1:0] glyph_sel,
  input  logic [CSEL_W-1:0] col_sel,
  output logic [WORD_W-1:0] col_bits
);
  localparam int unsigned DEPTH = NUM_GLYPHS * GLYPH_COLS;
  localparam int unsigned IDX_W = $clog2(DEPTH + 1);

  acc_kind_e         acc;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_parked;
  logic [WORD_W-1:0] cur_word;
  logic              resp_free;
  logic              rd_take;

  assign wr_ready = 1'b1;
  assign rd_ready = !wr_valid && resp_free;
  assign rd_take  = rd_valid && rd_ready;

  always_comb begin
    acc = ACC_IDLE;
    if (wr_valid) acc = wr_byte[CMD_BIT] ? ACC_CUR_WR : ACC_DATA_WR;
    else if (rd_take) acc = ACC_DATA_RD;
  end

  glyph_cursor #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .cur_off (wr_byte[6:0]),
    .idx     (cur_idx),
    .parked  (cur_parked)
  );

  glyph_cells #(
    .NUM_GLYPHS (NUM_GLYPHS),
    .GLYPH_COLS (GLYPH_COLS),
    .WORD_W     (WORD_W),
    .IDX_W      (IDX_W),
    .GSEL_W     (GSEL_W),
    .CSEL_W     (CSEL_W)
  ) u_cells (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        ((acc == ACC_DATA_WR) && !cur_parked),
    .wr_idx    (cur_idx),
    .wr_word   (wr_byte[WORD_W-1:0]),
    .rd_idx    (cur_idx),
    .rd_word   (cur_word),
    .glyph_sel (glyph_sel),
    .col_sel   (col_sel),
    .col_word  (col_bits)
  );

  glyph_resp #(
    .WORD_W (WORD_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_take),
    .word      (cur_word),
    .free      (resp_free),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_byte  (rsp_byte)
  );
endmodule

// File: rtl/glyph_store_chk.sv
module glyph_store_chk #(
  parameter int unsigned NUM_GLYPHS = 24,
  parameter int unsigned GLYPH_COLS = 5,
  parameter int unsigned WORD_W     = 7,
  parameter int unsigned GSEL_W     = 5,
  parameter int unsigned CSEL_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_byte,
  input logic [GSEL_W-1:0] glyph_sel,
  input logic [CSEL_W-1:0] col_sel,
  input logic [WORD_W-1:0] col_bits
);
  a_r5_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_byte[7]);

  a_r5_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  a_r8_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

  a_r8_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready);

  a_r9_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_ready);

  a_r7_glyph_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(glyph_sel) >= int'(NUM_GLYPHS)) |-> (col_bits == '0));

  a_r7_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(col_sel) >= int'(GLYPH_COLS)) |-> (col_bits == '0));
endmodule

bind glyph_store glyph_store_chk #(
  .NUM_GLYPHS (NUM_GLYPHS),
  .GLYPH_COLS (GLYPH_COLS),
  .WORD_W     (WORD_W),
  .GSEL_W     (GSEL_W),
  .CSEL_W     (CSEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_byte  (rsp_byte),
  .glyph_sel (glyph_sel),
  .col_sel   (col_sel),
  .col_bits  (col_bits)
);

// File: tb/glyph_store_test.sv
module glyph_store_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_byte = 8'h00;
  logic       rd_valid = 1'b0;
  logic       rd_ready;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_byte;
  logic [4:0] glyph_sel = 5'd0;
  logic [2:0] col_sel = 3'd0;
  logic [6:0] col_bits;

  always #2 clk = ~clk;

  glyph_store uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .glyph_sel(glyph_sel), .col_sel(col_sel), .col_bits(col_bits)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [6:0] mdl [120];
  int         mptr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Reference updates, derived from the requirements.
  task automatic mdl_write(input logic [7:0] b);
    if (b[7]) mptr = (b >= 8'hF8) ? 0 : int'(b) - 'h80;
    else if (mptr < 120) begin
      mdl[mptr] = b[6:0];
      mptr++;
    end
  endtask

  task automatic mdl_read(input string tag);
    logic [7:0] e;
    e = (mptr < 120) ? {1'b0, mdl[mptr]} : 8'h00;
    if (mptr < 120) mptr++;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_write(input logic [7:0] b);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_byte = b;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    mdl_write(b);
  endtask

  task automatic do_read(input string tag);
    @(posedge clk); #1;
    rd_valid = 1'b1;
    do @(negedge clk); while (!rd_ready);
    mdl_read(tag);
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic fetch(input int g, input int c, input int exp, input string tag);
    @(posedge clk); #1;
    glyph_sel = 5'(g); col_sel = 3'(c);
    @(negedge clk);
    chk(col_bits == 7'(exp), tag, col_bits, exp);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 100) begin
      @(posedge clk); n++;
    end
    @(posedge clk);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected response", rsp_byte, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_byte == e, t, rsp_byte, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R8 watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    for (int i = 0; i < 120; i++) mdl[i] = 7'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    chk(wr_ready == 1'b1, "R9 write always ready", wr_ready, 1);
    fetch(0, 0, 0, "R1 glyph 0 col 0 blank");
    fetch(23, 4, 0, "R1 glyph 23 col 4 blank");
    do_read("R1 first read is zero");

    // R2/R3: place cursor, load glyph 0, read back.
    do_write(8'h80);
    do_write(8'h15); do_write(8'h2A); do_write(8'h7F);
    do_write(8'h00); do_write(8'h41);
    do_write(8'h80);
    for (int i = 0; i < 5; i++) do_read("R2 glyph 0 stream readback");
    do_read("R5 read steps to location 5");
    fetch(0, 2, 'h7F, "R7 glyph 0 col 2");
    fetch(0, 4, 'h41, "R7 glyph 0 col 4");

    // R3: cursor into the middle, glyph 3 column 4 is location 19.
    do_write(8'h93); do_write(8'h33);
    fetch(3, 4, 'h33, "R3 cursor jump to glyph 3 col 4");
    fetch(4, 0, 0, "R2 neighbour untouched");
    do_write(8'h93);
    do_read("R3 readback at 0x93");

    // R4: clamping.
    do_write(8'hFA);
    do_read("R4 0xFA lands on location 0");
    do_write(8'hFF); do_write(8'h6C);
    fetch(0, 0, 'h6C, "R4 0xFF write lands on location 0");

    // R6: parking after the last write.
    do_write(8'hF6); do_write(8'h11); do_write(8'h22);
    do_write(8'h55);
    do_read("R6 parked read returns zero");
    fetch(23, 3, 'h11, "R6 location 118");
    fetch(23, 4, 'h22, "R6 location 119 not overwritten");
    fetch(0, 0, 'h6C, "R6 location 0 not touched");
    // Parking after a read.
    do_write(8'hF7);
    do_read("R6 read of last location");
    do_write(8'h44);
    do_read("R6 parked after read");
    fetch(23, 4, 'h22, "R6 write while parked ignored");
    do_write(8'hF7);
    do_read("R6 cursor byte releases park");

    // R7: range limits and no cursor disturbance.
    do_write(8'h81);
    fetch(24, 0, 0, "R7 glyph 24 out of range");
    fetch(31, 1, 0, "R7 glyph 31 out of range");
    fetch(0, 5, 0, "R7 col 5 out of range");
    fetch(0, 7, 0, "R7 col 7 out of range");
    do_read("R7 cursor undisturbed by fetch");
    drain();

    // R8: stalled consumer.
    rsp_ready = 1'b0;
    do_write(8'h80);
    do_read("R8 held response delivered");
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R8 response pending", rsp_valid, 1);
    chk(rd_ready == 1'b0, "R8 request blocked while full", rd_ready, 0);
    held = rsp_byte;
    repeat (3) @(negedge clk);
    chk(rsp_byte == held, "R8 byte stable under stall", rsp_byte, held);
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain();

    // R9: write and read offered together.
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_byte = 8'h82; rd_valid = 1'b1;
    @(negedge clk);
    chk(rd_ready == 1'b0, "R9 read held off by write", rd_ready, 0);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    mdl_write(8'h82);
    do @(negedge clk); while (!rd_ready);
    mdl_read("R9 read after concurrent cursor write");
    @(posedge clk); #1 rd_valid = 1'b0;
    drain();

    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule